// File: doc/BRIEF.md
# Descriptor-Table Scatter-Gather DMA Engine

This block is the bus-master data mover of a storage host port. Software lays out a table of region descriptors in system memory, loads the table's base address into a register, selects a direction and sets the start bit. The engine then works through the table on its own. For each entry it reads two 32-bit words over a request/grant memory port. It then moves the region's data one 32-bit beat at a time, either from the device word stream into memory or from memory out to the device. It stops after the entry that carries the end-of-table flag.

Each descriptor occupies 8 bytes. The first word holds the buffer address, with bit 0 serving as the end-of-table flag. The second word holds the byte count. A region may be as large as 512 MB, and it may cross any 64 KB boundary, because the engine simply increments a 32-bit address. A small register file handles control, sticky status, interrupt enables and the table base. A single interrupt line is the OR of the enabled status bits.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The register indices are 0 for control, 1 for status, 2 for interrupt enable and 3 for table base.
- R2: The descriptor for entry k is read from table base + 8k. The address word comes first and the length word at +4. Address bit 0 is the end flag, and bits 1:0 are cleared before the address is used for data.
- R3: With control bit 2 set (device to memory), each accepted device word is written to consecutive word addresses starting at the region address. A region of L bytes takes ceil(L/4) beats.
- R4: With control bit 2 clear (memory to device), the words read from consecutive region addresses are presented on the device output stream in order, ceil(L/4) beats per region.
- R5: When the last beat of the flagged descriptor completes, status bit 0 (active) falls and status bit 1 (normal end) is set. Writing 1 to status bit 1 clears it.
- R6: A descriptor with length zero causes no data cycle. The walk moves on to the next descriptor, or it ends with normal end if that descriptor is flagged.
- R7: A control write with bit 1 (stop) set during a transfer ends it at once. No normal end is raised, and no further memory or device cycle follows.
- R8: A memory error reported on a granted cycle sets status bit 2 and ends the transfer. Writing 1 to that bit clears it.
- R9: A high `dev_irq` sets status bit 4, which stays set until software writes 1 to it.
- R10: `irq` is high exactly when some status bit among 0, 1, 2 and 4 is set together with the same bit of the interrupt-enable register.
- R11: While control bit 7 (module reset) is set, status bits 1, 2 and 4 are held clear, and a start request is ignored.
- R12: Every memory request carries a word-aligned address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory cycle accepted this clock |
| mem_err | input | 1 | Granted cycle failed |
| mem_rdata | input | 32 | Read data, valid with grant |
| dev_in_valid | input | 1 | Device word available |
| dev_in_ready | output | 1 | Device word taken |
| dev_in_data | input | 32 | Device word |
| dev_out_valid | output | 1 | Word offered to device |
| dev_out_ready | input | 1 | Device accepts word |
| dev_out_data | output | 32 | Word to device |
| dev_irq | input | 1 | Device interrupt request |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach involve a stop request or a memory error in the middle of a walk. In those cases the engine must stay silent afterwards, even though the device keeps offering data. The stimulus holds the device stream idle so that the engine is parked inside a region, then issues the stop. Only after that does it release the stream and confirm that no word is consumed. For the error case, the failing address is pinned to the first descriptor word. Random grant stalls and random stream handshakes run underneath randomly sized multi-entry tables, which include zero-length entries.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
    typedef enum logic [1:0] {
        W_IDLE    = 2'd0,
        W_FETCH_A = 2'd1,
        W_FETCH_L = 2'd2,
        W_XFER    = 2'd3
    } walk_st_e;

    localparam logic [1:0] RI_CTL  = 2'd0;
    localparam logic [1:0] RI_STS  = 2'd1;
    localparam logic [1:0] RI_IEN  = 2'd2;
    localparam logic [1:0] RI_BASE = 2'd3;

    localparam int C_START = 0;
    localparam int C_STOP  = 1;
    localparam int C_DIR   = 2;
    localparam int C_RST   = 7;

    localparam int S_ACT  = 0;
    localparam int S_NEND = 1;
    localparam int S_ERR  = 2;
    localparam int S_DEV  = 4;
endpackage

// File: rtl/sgd_regs.sv
module sgd_regs
    import sgd_pkg::*;
#(
    parameter int AW  = 32,
    parameter int RAW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [AW-1:0]  reg_wdata,
    output logic [AW-1:0]  reg_rdata,
    input  logic           wk_active,
    input  logic           wk_done,
    input  logic           wk_err,
    input  logic           dev_irq,
    output logic           go,
    output logic           go_dir,
    output logic           abort,
    output logic           soft_rst,
    output logic [AW-1:0]  tbl_base,
    output logic           irq
);
    localparam int SW = S_DEV + 1;

    typedef struct packed {
        logic          dir;
        logic          rst;
        logic [SW-1:0] ien;
        logic          nend;
        logic          errf;
        logic          devf;
        logic [AW-1:0] base;
    } regs_s;

    regs_s r_d, r_q;
    logic  wr_ctl, wr_sts, wr_ien, wr_base;
    logic [SW-1:0] sts_vec;

    always_comb begin
        sts_vec        = '0;
        sts_vec[S_ACT]  = wk_active;
        sts_vec[S_NEND] = r_q.nend;
        sts_vec[S_ERR]  = r_q.errf;
        sts_vec[S_DEV]  = r_q.devf;
    end

    always_comb begin
        wr_ctl  = reg_we && (reg_addr == RAW'(RI_CTL));
        wr_sts  = reg_we && (reg_addr == RAW'(RI_STS));
        wr_ien  = reg_we && (reg_addr == RAW'(RI_IEN));
        wr_base = reg_we && (reg_addr == RAW'(RI_BASE));

        r_d = r_q;
        if (wr_ctl) begin
            r_d.dir = reg_wdata[C_DIR];
            r_d.rst = reg_wdata[C_RST];
        end
        if (wr_ien)  r_d.ien  = reg_wdata[SW-1:0];
        if (wr_base) r_d.base = reg_wdata;
        if (wr_sts) begin
            if (reg_wdata[S_NEND]) r_d.nend = 1'b0;
            if (reg_wdata[S_ERR])  r_d.errf = 1'b0;
            if (reg_wdata[S_DEV])  r_d.devf = 1'b0;
        end
        if (wk_done) r_d.nend = 1'b1;
        if (wk_err)  r_d.errf = 1'b1;
        if (dev_irq) r_d.devf = 1'b1;
        if (r_q.rst) begin
            r_d.nend = 1'b0;
            r_d.errf = 1'b0;
            r_d.devf = 1'b0;
        end

        go     = wr_ctl && reg_wdata[C_START] && !reg_wdata[C_STOP] &&
                 !reg_wdata[C_RST] && !r_q.rst && !wk_active;
        go_dir = reg_wdata[C_DIR];
        abort  = wr_ctl && reg_wdata[C_STOP] && wk_active;

        reg_rdata = '0;
        unique case (reg_addr)
            RAW'(RI_CTL): begin
                reg_rdata[C_START] = wk_active;
                reg_rdata[C_DIR]   = r_q.dir;
                reg_rdata[C_RST]   = r_q.rst;
            end
            RAW'(RI_STS):  reg_rdata[SW-1:0] = sts_vec;
            RAW'(RI_IEN):  reg_rdata[SW-1:0] = r_q.ien;
            default:       reg_rdata = r_q.base;
        endcase
    end

    assign soft_rst = r_q.rst;
    assign tbl_base = r_q.base;
    assign irq      = |(sts_vec & r_q.ien);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    p_nend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_done && !r_q.rst) |=> r_q.nend);
    p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_err && !r_q.rst) |=> r_q.errf);
    p_srst_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rst |=> (!r_q.nend && !r_q.errf && !r_q.devf));
endmodule

// File: rtl/sgd_walker.sv
module sgd_walker
    import sgd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          go_dir,
    input  logic          abort,
    input  logic          soft_rst,
    input  logic [AW-1:0] tbl_base,
    output logic          active,
    output logic          done,
    output logic          err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_err,
    input  logic [DW-1:0] mem_rdata,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [DW-1:0] dev_in_data,
    output logic          dev_out_valid,
    input  logic          dev_out_ready,
    output logic [DW-1:0] dev_out_data
);
    localparam logic [AW-1:0] BEAT  = AW'(DW / 8);
    localparam logic [AW-1:0] DWORD = AW'(4);

    typedef struct packed {
        walk_st_e      st;
        logic [AW-1:0] ptr;
        logic [AW-1:0] bufa;
        logic [AW-1:0] len;
        logic          last;
        logic          dir;
    } walk_s;

    walk_s w_d, w_q;
    logic  beat;

    always_comb begin
        w_d           = w_q;
        done          = 1'b0;
        err           = 1'b0;
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = '0;
        mem_wdata     = dev_in_data;
        dev_in_ready  = 1'b0;
        dev_out_valid = 1'b0;
        dev_out_data  = mem_rdata;
        beat          = 1'b0;

        unique case (w_q.st)
            W_IDLE: begin
                if (go) begin
                    w_d.st  = W_FETCH_A;
                    w_d.ptr = {tbl_base[AW-1:2], 2'b00};
                    w_d.dir = go_dir;
                end
            end
            W_FETCH_A: begin
                mem_req  = 1'b1;
                mem_addr = w_q.ptr;
                if (mem_gnt) begin
                    if (mem_err) begin
                        err      = 1'b1;
                        w_d.st   = W_IDLE;
                    end else begin
                        w_d.bufa = {mem_rdata[AW-1:2], 2'b00};
                        w_d.last = mem_rdata[0];
                        w_d.ptr  = w_q.ptr + DWORD;
                        w_d.st   = W_FETCH_L;
                    end
                end
            end
            W_FETCH_L: begin
                mem_req  = 1'b1;
                mem_addr = w_q.ptr;
                if (mem_gnt) begin
                    if (mem_err) begin
                        err     = 1'b1;
                        w_d.st  = W_IDLE;
                    end else begin
                        w_d.len = mem_rdata[AW-1:0];
                        w_d.ptr = w_q.ptr + DWORD;
                        if (mem_rdata == '0) begin
                            if (w_q.last) begin
                                done   = 1'b1;
                                w_d.st = W_IDLE;
                            end else begin
                                w_d.st = W_FETCH_A;
                            end
                        end else begin
                            w_d.st = W_XFER;
                        end
                    end
                end
            end
            W_XFER: begin
                mem_addr = w_q.bufa;
                if (w_q.dir) begin
                    mem_req      = dev_in_valid;
                    mem_we       = 1'b1;
                    dev_in_ready = mem_gnt;
                end else begin
                    mem_req       = dev_out_ready;
                    dev_out_valid = mem_gnt;
                end
                beat = mem_req && mem_gnt;
                if (beat) begin
                    if (mem_err) begin
                        err    = 1'b1;
                        w_d.st = W_IDLE;
                    end else begin
                        w_d.bufa = w_q.bufa + BEAT;
                        if (w_q.len <= BEAT) begin
                            w_d.len = '0;
                            if (w_q.last) begin
                                done   = 1'b1;
                                w_d.st = W_IDLE;
                            end else begin
                                w_d.st = W_FETCH_A;
                            end
                        end else begin
                            w_d.len = w_q.len - BEAT;
                        end
                    end
                end
            end
            default: w_d.st = W_IDLE;
        endcase

        if (abort || soft_rst) begin
            w_d.st = W_IDLE;
            done   = 1'b0;
        end
    end

    assign active = (w_q.st != W_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{st: W_IDLE, default: '0};
        else        w_q <= w_d;
    end

    p_aligned_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    p_abort_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !active);
    p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.st == W_FETCH_L && mem_gnt && !mem_err && mem_rdata == '0 &&
         !abort && !soft_rst) |=> (w_q.st != W_XFER));
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active);
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
    import sgd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_in_valid,
    output logic              dev_in_ready,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_out_valid,
    input  logic              dev_out_ready,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_irq,
    output logic              irq
);
    logic              go, go_dir, abort, soft_rst;
    logic              wk_active, wk_done, wk_err;
    logic [ADDR_W-1:0] tbl_base;

    sgd_regs #(.AW(ADDR_W), .RAW(REG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wk_active (wk_active),
        .wk_done   (wk_done),
        .wk_err    (wk_err),
        .dev_irq   (dev_irq),
        .go        (go),
        .go_dir    (go_dir),
        .abort     (abort),
        .soft_rst  (soft_rst),
        .tbl_base  (tbl_base),
        .irq       (irq)
    );

    sgd_walker #(.AW(ADDR_W), .DW(DATA_W)) u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (go),
        .go_dir        (go_dir),
        .abort         (abort),
        .soft_rst      (soft_rst),
        .tbl_base      (tbl_base),
        .active        (wk_active),
        .done          (wk_done),
        .err           (wk_err),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_gnt       (mem_gnt),
        .mem_err       (mem_err),
        .mem_rdata     (mem_rdata),
        .dev_in_valid  (dev_in_valid),
        .dev_in_ready  (dev_in_ready),
        .dev_in_data   (dev_in_data),
        .dev_out_valid (dev_out_valid),
        .dev_out_ready (dev_out_ready),
        .dev_out_data  (dev_out_data)
    );
endmodule

// File: tb/sg_dma_engine_bench.sv
module sg_dma_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_gnt, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        dev_in_valid, dev_in_ready, dev_out_valid, dev_out_ready;
    logic [31:0] dev_in_data, dev_out_data;
    logic        dev_irq = 1'b0;
    logic        irq;

    logic [31:0] mem [0:1023];
    logic        stall_q = 1'b0, vrnd = 1'b0, rrnd = 1'b0;
    logic        in_en = 1'b1, out_en = 1'b1, stall_en = 1'b1;
    logic        err_arm = 1'b0;
    logic [31:0] err_addr = '0;
    int unsigned din_cnt = 0, out_cnt = 0, misalign = 0;
    logic [31:0] out_buf [0:4095];
    int          tests = 0, fails = 0;
    int unsigned d_addr [4];
    int unsigned d_len [4];

    localparam logic [31:0] SENT = 32'hDEAD_BEEF;
    localparam logic [31:0] TBL  = 32'h400;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] src_word(int unsigned n);
        return 32'hC0DE_0000 ^ (n * 32'h9E37_79B1);
    endfunction

    assign mem_gnt       = !stall_q;
    assign mem_rdata     = mem[mem_addr[11:2]];
    assign mem_err       = err_arm && (mem_addr == err_addr);
    assign dev_in_valid  = in_en && vrnd;
    assign dev_in_data   = src_word(din_cnt);
    assign dev_out_ready = out_en && rrnd;

    sg_dma_engine u_sg_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
        .dev_in_data(dev_in_data), .dev_out_valid(dev_out_valid),
        .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
        .dev_irq(dev_irq), .irq(irq)
    );

    always @(negedge clk) begin
        stall_q <= stall_en && (($urandom % 4) == 0);
        vrnd    <= (($urandom % 3) != 0);
        rrnd    <= (($urandom % 3) != 0);
    end

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_gnt && !mem_err) mem[mem_addr[11:2]] <= mem_wdata;
        if (dev_in_valid && dev_in_ready) din_cnt <= din_cnt + 1;
        if (dev_out_valid && dev_out_ready) begin
            out_buf[out_cnt[11:0]] <= dev_out_data;
            out_cnt <= out_cnt + 1;
        end
        if (rst_n && mem_req && mem_addr[1:0] != 2'b00) misalign <= misalign + 1;
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] s;
        int k;
        for (k = 0; k < 4000; k++) begin
            reg_read(2'd1, s);
            if (!s[0]) break;
        end
        check(32'(k < 4000), 32'd1, req);
    endtask

    task automatic run_xfer(input int nd, input logic dir, input string tag);
        int unsigned in0, o0, idx;
        logic [31:0] s;
        idx = 0;
        for (int k = 0; k < nd; k++) begin
            mem[(TBL >> 2) + 2*k]     = d_addr[k] | 32'(k == nd - 1);
            mem[(TBL >> 2) + 2*k + 1] = d_len[k];
            for (int w = 0; w <= int'((d_len[k] + 3) / 4); w++)
                mem[(d_addr[k] >> 2) + w] = dir ? SENT : src_word(5000 + 64*k + w);
        end
        in0 = din_cnt; o0 = out_cnt;
        reg_write(2'd3, TBL);
        reg_write(2'd0, {29'd0, dir, 2'b01});
        wait_idle(tag);
        for (int k = 0; k < nd; k++) begin
            for (int w = 0; w < int'((d_len[k] + 3) / 4); w++) begin
                if (dir) check(mem[(d_addr[k] >> 2) + w], src_word(in0 + idx), {tag, " R3 data"});
                else     check(out_buf[(o0 + idx) % 4096], src_word(5000 + 64*k + w), {tag, " R4 data"});
                idx++;
            end
            if (dir) check(mem[(d_addr[k] >> 2) + (d_len[k] + 3) / 4], SENT, {tag, " R3 region end"});
        end
        if (dir) check(din_cnt - in0, idx, {tag, " R3 beat count"});
        else     check(out_cnt - o0, idx, {tag, " R4 beat count"});
        reg_read(2'd1, s);
        check(s, 32'h2, {tag, " R5 normal end"});
        reg_write(2'd1, 32'h2);
        reg_read(2'd1, s);
        check(s, 32'h0, {tag, " R5 clear"});
    endtask

    initial begin
        logic [31:0] r;
        int unsigned c0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), r);
            check(r, 32'h0, "R1 reset register");
        end
        check(32'(irq), 32'h0, "R1 irq at reset");

        // R2/R3: flagged address with bit 0 set is masked; partial final word
        d_addr[0] = 32'h800; d_len[0] = 12;
        d_addr[1] = 32'h900; d_len[1] = 6;
        run_xfer(2, 1'b1, "R2 dir1 directed");
        // R4 directed
        run_xfer(2, 1'b0, "R4 dir0 directed");
        // R6 zero-length entries: middle and flagged last
        d_addr[0] = 32'h800; d_len[0] = 0;
        d_addr[1] = 32'h900; d_len[1] = 4;
        d_addr[2] = 32'hA00; d_len[2] = 0;
        run_xfer(3, 1'b1, "R6 zero-length");
        run_xfer(1, 1'b0, "R6 single zero-length");

        // random tables
        for (int it = 0; it < 24; it++) begin
            int nd;
            nd = 1 + int'($urandom % 4);
            for (int k = 0; k < nd; k++) begin
                d_addr[k] = 32'h800 + 32'h100 * k;
                d_len[k]  = $urandom % 41;
            end
            run_xfer(nd, 1'($urandom % 2), "R3/R4 random");
        end

        // R10 irq on normal end
        reg_write(2'd2, 32'h02);
        d_addr[0] = 32'h800; d_len[0] = 8;
        mem[TBL >> 2] = 32'h801; mem[(TBL >> 2) + 1] = 32'd8;
        reg_write(2'd3, TBL);
        reg_write(2'd0, 32'h5);
        wait_idle("R10 run");
        #1 check(32'(irq), 32'h1, "R10 irq on enabled normal end");
        reg_write(2'd1, 32'h2);
        #1 check(32'(irq), 32'h0, "R10 irq after clear");

        // R7 abort mid-region with device idle
        in_en = 1'b0;
        mem[TBL >> 2] = 32'h801; mem[(TBL >> 2) + 1] = 32'd64;
        reg_write(2'd0, 32'h5);
        repeat (12) @(negedge clk);
        reg_write(2'd0, 32'h2);
        reg_read(2'd1, r);
        check(r, 32'h0, "R7 stopped without normal end");
        c0 = din_cnt;
        in_en = 1'b1;
        repeat (20) @(negedge clk);
        check(din_cnt, c0, "R7 no data after stop");
        check(32'(irq), 32'h0, "R7 no irq");

        // R8 memory error on descriptor fetch
        err_arm = 1'b1; err_addr = TBL;
        c0 = din_cnt;
        reg_write(2'd0, 32'h5);
        wait_idle("R8 run");
        reg_read(2'd1, r);
        check(r, 32'h4, "R8 error flag");
        check(din_cnt, c0, "R8 no data moved");
        err_arm = 1'b0;
        reg_write(2'd1, 32'h4);
        reg_read(2'd1, r);
        check(r, 32'h0, "R8 error clear");

        // R9 device interrupt, R10 with its enable
        reg_write(2'd2, 32'h10);
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk); dev_irq = 1'b0;
        repeat (3) @(negedge clk);
        reg_read(2'd1, r);
        check(r, 32'h10, "R9 device flag sticky");
        check(32'(irq), 32'h1, "R10 irq on device flag");

        // R11 module reset clears sticky bits and blocks start
        reg_write(2'd0, 32'h80);
        reg_write(2'd0, 32'h81);
        repeat (3) @(negedge clk);
        reg_read(2'd1, r);
        check(r, 32'h0, "R11 status held clear, start ignored");
        reg_read(2'd0, r);
        check(r, 32'h80, "R11 control readback");
        reg_write(2'd0, 32'h0);
        reg_write(2'd1, 32'h10);

        // R9 W1C
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk); dev_irq = 1'b0;
        reg_write(2'd1, 32'h10);
        reg_read(2'd1, r);
        check(r, 32'h0, "R9 device flag clear");

        check(misalign, 32'd0, "R12 aligned requests");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule